// File: doc/BRIEF.md
# Elastic Bit Store with Self-Checking Read-Back

A 16-entry circular bit store sits between a serial producer and a serial consumer. Each write beat stores one bit at a 4-bit write address that then advances. Each read beat loads the bit at an independent 4-bit read address into a one-bit output buffer, and the read address then advances. Both addresses wrap modulo 16. Neither side applies back-pressure. A write beat (`in_valid` high) is always accepted, so there is no ready output. A read beat (`out_ready` high) always loads the buffer. Keeping the two rates in step is the job of the surrounding logic.

A built-in diagnostic checks that the store returns what was put into it. A capture strobe that coincides with a write beat records the write address and the bit written. Later the live read address reaches the recorded address. On that read beat a diagnostic flag is set for one cycle. During that cycle the recorded bit is compared with the bit now held in the output buffer. If the writer has lapped the reader and overwritten that entry in the meantime, the two bits differ.

The mismatch is combined with two external driver error inputs into a sticky composite error. A clear input removes the composite error, and a self-test input forces the composite error on.

Top module: `es_diag_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `card_err` is 0 and `out_data` is 0. The write address, the read address and every store entry start at 0.
- R2: When `in_valid` is high at a clock edge, `in_data` is stored at the current write address and the write address advances by one, wrapping modulo 16.
- R3: When `out_ready` is high at a clock edge, `out_data` takes the entry at the current read address from that edge on, and the read address advances by one. As long as the writer never laps the reader, bits come out in the order they were written.
- R4: A capture is taken when `cap_strobe` and `in_valid` are both high at an edge and no check is pending. The capture records the write address and `in_data`, and marks a check as pending.
- R5: The check completes on the first read beat whose read address equals the recorded address. In the cycle after that beat, the recorded bit is compared with `out_data`. After the comparison the check is no longer pending.
- R6: If the entry still holds the bit that was captured, the comparison raises no error.
- R7: If the compared bits differ, `card_err` is 1 from the second edge after the matching read beat.
- R8: While a check is pending, any further capture strobe is ignored. Only the first capture decides which entry is checked.
- R9: A 1 on `drv_data_err` or `drv_timing_err` at an edge sets `card_err` from that edge on.
- R10: Once set, `card_err` stays at 1 after all error sources go low, until it is cleared.
- R11: `err_clear` high at an edge makes `card_err` 0 after that edge. This holds even when an error source is active at the same edge.
- R12: While `self_test` is high, `card_err` is 1 in the same cycle, whatever the stored error state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Write beat; always accepted |
| in_data | input | 1 | Bit written on a write beat |
| cap_strobe | input | 1 | Capture request for the bit written on this beat |
| out_ready | input | 1 | Read beat; loads the output buffer |
| out_data | output | 1 | Output buffer bit |
| drv_data_err | input | 1 | External data driver error |
| drv_timing_err | input | 1 | External timing driver error |
| err_clear | input | 1 | Clears the composite error |
| self_test | input | 1 | Forces the composite error on |
| card_err | output | 1 | Composite sticky error |

## Verification
The hardest case to reach is a real mismatch, because the store has no fault-injection port. With correct sequencing, the captured bit is always still in place when the reader arrives. The stimulus produces the mismatch by overrunning the store. It writes a full second lap of inverted bits after the capture and before any reads, so the checked entry is overwritten before the reader reaches it.

A variant of this overrun tests the ignored second strobe. Two strobes are issued, and only the entry of the second strobe is altered in the second lap. The composite error must stay low, which shows that the later strobe did not replace the first capture.

// File: rtl/es_diag_pkg.sv
package es_diag_pkg;
  parameter int unsigned ES_AW = 4;

  typedef struct packed {
    logic timing_err;
    logic data_err;
    logic cmp_err;
  } es_err_src_t;

  localparam int unsigned ES_NSRC = $bits(es_err_src_t);
endpackage

// File: rtl/es_store.sv
module es_store #(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_bit,
  input  logic          rd_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          buf_bit
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DEPTH-1:0] cells;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)
        cells[g] <= 1'b0;
      else if (wr_en && (wr_addr == AW'(g)))
        cells[g] <= wr_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_addr <= '0;
      rd_addr <= '0;
      buf_bit <= 1'b0;
    end else begin
      if (wr_en) wr_addr <= wr_addr + 1'b1;
      if (rd_en) begin
        buf_bit <= cells[rd_addr];
        rd_addr <= rd_addr + 1'b1;
      end
    end
  end

  assert_wr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> wr_addr == AW'($past(wr_addr) + 1'b1));
  assert_wr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wr_addr));
  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_addr) && $stable(buf_bit));
endmodule

// File: rtl/es_diag_cmp.sv
module es_diag_cmp #(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          buf_bit,
  output logic          cmp_err
);
  logic          pending;
  logic          diag_q;
  logic [AW-1:0] lat_addr;
  logic          lat_bit;
  logic          take;
  logic          hit;

  assign take = cap_en && !pending;
  assign hit  = pending && !diag_q && rd_en && (rd_addr == lat_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      diag_q   <= 1'b0;
      lat_addr <= '0;
      lat_bit  <= 1'b0;
    end else begin
      if (take) begin
        lat_addr <= wr_addr;
        lat_bit  <= wr_bit;
        pending  <= 1'b1;
      end else if (diag_q) begin
        pending  <= 1'b0;
      end
      diag_q <= hit;
    end
  end

  assign cmp_err = diag_q && (buf_bit != lat_bit);

  assert_ignore_while_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && cap_en) |=> $stable(lat_addr) && $stable(lat_bit));
  assert_cmp_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    diag_q |=> !diag_q);
  assert_cmp_needs_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    diag_q |-> pending);
  assert_check_retires_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_q && !cap_en) |=> !pending);
endmodule

// File: rtl/es_err_comp.sv
module es_err_comp #(
  parameter int unsigned NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic            clear,
  input  logic            self_test,
  output logic            err_out
);
  logic sticky;

  always_ff @(posedge clk) begin
    if (!rst_n)        sticky <= 1'b0;
    else if (clear)    sticky <= 1'b0;
    else if (|src)     sticky <= 1'b1;
  end

  assign err_out = sticky | self_test;

  assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (self_test || !err_out));
  assert_src_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|src) && !clear) |=> err_out);
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_out && !self_test && !clear) |=> err_out);
endmodule

// File: rtl/es_diag_top.sv
module es_diag_top
  import es_diag_pkg::*;
#(
  parameter int unsigned AW = ES_AW
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_data,
  input  logic cap_strobe,
  input  logic out_ready,
  output logic out_data,
  input  logic drv_data_err,
  input  logic drv_timing_err,
  input  logic err_clear,
  input  logic self_test,
  output logic card_err
);
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  logic          cmp_err;
  es_err_src_t   srcs;

  es_store #(.AW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (in_valid),
    .wr_bit  (in_data),
    .rd_en   (out_ready),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .buf_bit (out_data)
  );

  es_diag_cmp #(.AW(AW)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (cap_strobe && in_valid),
    .wr_addr (wr_addr),
    .wr_bit  (in_data),
    .rd_en   (out_ready),
    .rd_addr (rd_addr),
    .buf_bit (out_data),
    .cmp_err (cmp_err)
  );

  assign srcs.cmp_err    = cmp_err;
  assign srcs.data_err   = drv_data_err;
  assign srcs.timing_err = drv_timing_err;

  es_err_comp #(.NSRC(ES_NSRC)) u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .src       (srcs),
    .clear     (err_clear),
    .self_test (self_test),
    .err_out   (card_err)
  );

  always_comb begin
    if (rst_n && self_test)
      assert_selftest_forces_R12: assert (card_err);
  end
endmodule

// File: tb/es_diag_top_test.sv
module es_diag_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_data = 1'b0, cap_strobe = 1'b0, out_ready = 1'b0;
  logic drv_data_err = 1'b0, drv_timing_err = 1'b0, err_clear = 1'b0, self_test = 1'b0;
  logic out_data, card_err;
  int ncmp = 0;
  int nmis = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  es_diag_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .cap_strobe(cap_strobe), .out_ready(out_ready), .out_data(out_data),
    .drv_data_err(drv_data_err), .drv_timing_err(drv_timing_err),
    .err_clear(err_clear), .self_test(self_test), .card_err(card_err)
  );

  // {exp_err, mode[1:0], cap_idx[3:0], pattern[15:0]}
  // mode 0: clean, 1: full inverted overrun, 2: double strobe + overwrite of second entry
  localparam logic [22:0] VEC [6] = '{
    {1'b0, 2'd0, 4'd3,  16'hA5C3},
    {1'b0, 2'd0, 4'd9,  16'h0F0F},
    {1'b1, 2'd1, 4'd6,  16'h1234},
    {1'b1, 2'd1, 4'd0,  16'hFFFF},
    {1'b0, 2'd2, 4'd2,  16'h5A5A},
    {1'b0, 2'd0, 4'd15, 16'h8001}
  };

  task automatic check(input logic act, input logic exp, input string tag);
    ncmp++;
    if (act !== exp) begin
      nmis++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic b, input logic s);
    @(negedge clk); in_valid = 1'b1; in_data = b; cap_strobe = s;
    @(negedge clk); in_valid = 1'b0; in_data = 1'b0; cap_strobe = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(negedge clk); err_clear = 1'b1;
    @(negedge clk); err_clear = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nmis++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nmis);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    idle(3);
    check(card_err, 1'b0, "R1 card_err in reset");
    check(out_data, 1'b0, "R1 out_data in reset");
    rst_n = 1'b1;
    idle(1);
    check(card_err, 1'b0, "R1 card_err after reset");
    rd();
    check(out_data, 1'b0, "R1 store cleared by reset");
    wr(1'b0, 1'b0); // rebalance write/read counts

    for (int v = 0; v < 6; v++) begin
      logic [15:0] pat;
      int k, k2, mode;
      logic exp;
      pat = VEC[v][15:0]; k = int'(VEC[v][19:16]);
      mode = int'(VEC[v][21:20]); exp = VEC[v][22];
      k2 = (k + 5) % 16;
      for (int i = 0; i < 16; i++)
        wr(pat[i], (i == k) || (mode == 2 && i == k2));
      if (mode != 0)
        for (int i = 0; i < 16; i++)
          wr((mode == 1) ? ~pat[i] : (i == k2 ? ~pat[i] : pat[i]), 1'b0);
      for (int i = 0; i < ((mode == 0) ? 16 : 32); i++) begin
        rd();
        if (mode == 0) check(out_data, pat[i], "R2 R3 read order");
        if (mode == 1 && i < 16) check(out_data, ~pat[i], "R2 R3 overrun data");
      end
      idle(2);
      if (mode == 0)      check(card_err, exp, "R4 R5 R6 clean capture");
      else if (mode == 1) check(card_err, exp, "R5 R7 overrun mismatch");
      else                check(card_err, exp, "R8 second strobe ignored");
      pulse_clear();
      check(card_err, 1'b0, "R11 clear after scenario");
    end

    // R7: exact timing of the error after the matching read
    for (int i = 0; i < 16; i++) wr(1'b1, i == 4);
    for (int i = 0; i < 16; i++) wr(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) rd();
    @(negedge clk); out_ready = 1'b1;     // read beat at captured address
    @(negedge clk); out_ready = 1'b0;
    check(card_err, 1'b0, "R7 not yet set one edge after match");
    @(negedge clk);
    check(card_err, 1'b1, "R7 set two edges after match");
    for (int i = 5; i < 32; i++) rd();
    pulse_clear();

    // R9 / R10: driver errors are sticky
    @(negedge clk); drv_data_err = 1'b1;
    @(negedge clk); drv_data_err = 1'b0;
    check(card_err, 1'b1, "R9 data driver error");
    idle(3);
    check(card_err, 1'b1, "R10 sticky after source drops");
    pulse_clear();
    check(card_err, 1'b0, "R11 cleared");
    @(negedge clk); drv_timing_err = 1'b1;
    @(negedge clk); drv_timing_err = 1'b0;
    check(card_err, 1'b1, "R9 timing driver error");
    pulse_clear();

    // R11: clear wins over a simultaneous error
    @(negedge clk); drv_timing_err = 1'b1; err_clear = 1'b1;
    @(negedge clk); drv_timing_err = 1'b0; err_clear = 1'b0;
    check(card_err, 1'b0, "R11 clear priority");

    // R12: self-test forces error combinationally
    @(negedge clk); self_test = 1'b1;
    #1 check(card_err, 1'b1, "R12 self test forces");
    @(negedge clk); self_test = 1'b0;
    #1 check(card_err, 1'b0, "R12 released");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nmis);
    $finish;
  end
endmodule